// File: doc/BRIEF.md
# Indexed Register Port

This block is a slave on a 16-bit host bus with a select line for the command phase. A write in the command phase picks which 8-bit register index the following data phases address. Each data read or write then reaches the selected register. After the access, the index moves on to the next even register. Three streaming ports are the exception: when the index points at one of them, the index stays where it is, and the port's own internal pointer steps instead. That lets the host pour a whole table through one register.

Behind the port is a small register set. Four 10-bit window coordinates are each split into a low-byte register and a high-field register. There is a clock divider field with an offset encoding, two tables that are loaded through index and data register pairs, and a bank of matrix coefficients with a partial bit mask. A fixed identity readback and a status register with a forced bit are also present, along with an interrupt status register that the host clears by writing. After reset, a programmable number of bus accesses is absorbed without any effect, which covers a host that issues dummy cycles while it starts up.

Top module: `indexed_reg_port`

## Requirements
- R1: A write with `busCmd` high loads the register index from `busWData[7:0]`. Reads are always data accesses, whatever `busCmd` is.
- R2: After a data access the index advances by 2, modulo 256. It holds instead when the index is 0x90 (memory data port), 0x5A (filter data port) or 0xB8 (gamma data port).
- R3: The first `SWALLOW_COUNT` accesses after reset, reads or writes, have no effect. They do not change the index or any register, and `busRData` keeps its previous value (0 after reset). The default count is 2.
- R4: The filter index at 0x58 takes its value from bits 4:0 of a write. At 0x5A, while the filter index is below 32, each access reads or writes entry [index] and then increments the index. Once the index is 32, accesses at 0x5A write nothing, read 0 and leave the index at 32. Reading 0x58 returns the index.
- R5: The gamma index at 0xB6 is 8 bits. Each access at 0xB8 reads or writes entry [index] of a 256-entry table, then increments the index, wrapping from 255 to 0.
- R6: Coordinate k (k = 0..3) has its bits 7:0 at 0x6C+4k and its bits 9:8 at 0x6E+4k, written from data bits 1:0. Each write changes only its own field. The high register reads back bits 9:8 in bits 1:0.
- R7: A write of v to 0x04 stores (v & 0x3F) + 1. A read returns (stored − 1) | 0x80. After reset the register reads 0x80.
- R8: Bits of the interrupt status at 0xF6 are set by pulses on `gpioEvent`. A write ANDs the status with the written byte. `gpioIrq` is high while any status bit is set.
- R9: 0x02 always reads 0x83 and ignores writes. 0xE8 stores a written byte masked with 0x1B and always reads with bit 5 set, so it reads 0x20 after reset.
- R10: Matrix coefficient j sits at 0xBC+2j (j = 0..17). On a write, only bit 7 is kept when address bit 1 is set; otherwise all 8 bits are kept. All coefficients reset to 0.
- R11: Read data appears on `busRData` on the clock edge that takes the read and stays there until the next read. Its upper byte is 0. Unmapped indices and the memory data port read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busCmd | input | 1 | High for a command-phase write |
| busWData | input | 16 | Write data |
| gpioEvent | input | 8 | Event pulses that set interrupt status bits |
| busRData | output | 16 | Registered read data |
| gpioIrq | output | 1 | High while any interrupt status bit is set |

## Verification
The bench goes after the points where the index does something unusual:
- **Wrap from 0xFE to 0x00.** An adder of the wrong width would leave the index pointing past the map.
- **Hold on each streaming port.** A design that advanced there would send table bytes into neighbouring registers.
- **Filter pointer at its cap of 32.** A design that let the pointer wrap would overwrite entry 0.
- **Gamma pointer wrap from 255 to 0.**
- **Swallow window.** A swallowed command that was taken anyway would move the index, and the first real reads would return the wrong registers.
- **Coordinate high and low fields.** Random writes to both fields catch a write that clobbers the other half.
- **Register encodings.** The divider offset, the coefficient mask and the write-to-clear AND each get directed values on both sides of their bit boundaries.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam logic [7:0] ADDR_ID         = 8'h02;
  localparam logic [7:0] ADDR_PLL        = 8'h04;
  localparam logic [7:0] ADDR_FILT_IDX   = 8'h58;
  localparam logic [7:0] ADDR_FILT_DATA  = 8'h5A;
  localparam logic [7:0] ADDR_COORD_BASE = 8'h6C;
  localparam logic [7:0] ADDR_MEM_DATA   = 8'h90;
  localparam logic [7:0] ADDR_GAMMA_IDX  = 8'hB6;
  localparam logic [7:0] ADDR_GAMMA_DATA = 8'hB8;
  localparam logic [7:0] ADDR_COEF_BASE  = 8'hBC;
  localparam logic [7:0] ADDR_NDP        = 8'hE8;
  localparam logic [7:0] ADDR_GPIO_IRQ   = 8'hF6;
  localparam logic [7:0] ID_VALUE        = 8'h83;

  // Strobes from control to the register datapath
  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] idx;
    logic [7:0] wdata;
  } portStrobe_t;

  function automatic logic isStreamPort(input logic [7:0] idx);
    return (idx == ADDR_MEM_DATA) || (idx == ADDR_FILT_DATA) || (idx == ADDR_GAMMA_DATA);
  endfunction
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int SWALLOW_COUNT = 2,
  parameter int STEP          = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrite,
  input  logic        busRead,
  input  logic        busCmd,
  input  logic [15:0] busWData,
  output portStrobe_t strobe
);
  localparam int SW_W = $clog2(SWALLOW_COUNT + 2);

  logic [SW_W-1:0] swallowCnt;
  logic [7:0]      curIdx;
  logic            access, swallowing, live, cmdWrite, dataAcc;
  logic            unusedHiByte;

  assign access     = busWrite | busRead;
  assign swallowing = (swallowCnt != '0);
  assign live       = access && !swallowing;
  assign cmdWrite   = live && busWrite && busCmd;
  assign dataAcc    = live && !(busWrite && busCmd);
  assign unusedHiByte = ^busWData[15:8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swallowCnt <= SW_W'(SWALLOW_COUNT);
      curIdx     <= '0;
    end else if (access && swallowing) begin
      swallowCnt <= swallowCnt - 1'b1;
    end else if (cmdWrite) begin
      curIdx <= busWData[7:0];
    end else if (dataAcc && !isStreamPort(curIdx)) begin
      curIdx <= curIdx + 8'(STEP);
    end
  end

  always_comb begin
    strobe.wr    = dataAcc && busWrite;
    strobe.rd    = dataAcc && !busWrite;
    strobe.idx   = curIdx;
    strobe.wdata = busWData[7:0];
  end

  assert_cmd_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> curIdx == $past(busWData[7:0]));
  assert_stream_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && isStreamPort(curIdx)) |=> $stable(curIdx));
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !isStreamPort(curIdx)) |=> curIdx == $past(curIdx) + 8'(STEP));
  assert_swallow_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (access && swallowing) |=> (swallowCnt == $past(swallowCnt) - 1'b1) && $stable(curIdx));
  assert_swallow_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    swallowing |-> !strobe.wr && !strobe.rd);
endmodule

// File: rtl/regport_regs.sv
module regport_regs
  import regport_pkg::*;
#(
  parameter int NUM_COORD   = 4,
  parameter int COORD_W     = 10,
  parameter int FILT_DEPTH  = 32,
  parameter int GAMMA_DEPTH = 256,
  parameter int NUM_COEF    = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t strobe,
  input  logic [7:0]  gpioEvent,
  output logic [15:0] busRData,
  output logic        gpioIrq
);
  localparam int HI_W     = COORD_W - 8;
  localparam int FILT_IW  = $clog2(FILT_DEPTH) + 1;
  localparam int GAMMA_IW = $clog2(GAMMA_DEPTH);

  logic [COORD_W-1:0]  coord [NUM_COORD];
  logic [7:0]          coef [NUM_COEF];
  logic [7:0]          filtMem [FILT_DEPTH];
  logic [7:0]          gammaMem [GAMMA_DEPTH];
  logic [FILT_IW-1:0]  filtIdx;
  logic [GAMMA_IW-1:0] gammaIdx;
  logic [6:0]          pllDiv;
  logic [7:0]          ndpReg, gpioStatus, rdByte;
  logic [8:0]          coordOff, coefOff;
  logic                coordHit, coefHit, filtOpen, filtAcc, gammaAcc, anyAcc;

  assign anyAcc   = strobe.wr | strobe.rd;
  assign coordOff = {1'b0, strobe.idx} - {1'b0, ADDR_COORD_BASE};
  assign coefOff  = {1'b0, strobe.idx} - {1'b0, ADDR_COEF_BASE};
  assign coordHit = coordOff < 9'(4 * NUM_COORD);
  assign coefHit  = coefOff < 9'(2 * NUM_COEF);
  assign filtOpen = filtIdx < FILT_IW'(FILT_DEPTH);
  assign filtAcc  = anyAcc && strobe.idx == ADDR_FILT_DATA;
  assign gammaAcc = anyAcc && strobe.idx == ADDR_GAMMA_DATA;

  // Split coordinate fields
  for (genvar k = 0; k < NUM_COORD; k++) begin : g_coord
    always_ff @(posedge clk) begin
      if (!rstN) coord[k] <= '0;
      else if (strobe.wr && coordHit && coordOff[8:2] == 7'(k)) begin
        if (coordOff[1]) coord[k][COORD_W-1:8] <= strobe.wdata[HI_W-1:0];
        else             coord[k][7:0]         <= strobe.wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < NUM_COEF; j++) coef[j] <= '0;
      filtIdx    <= '0;
      gammaIdx   <= '0;
      pllDiv     <= 7'd1;
      ndpReg     <= '0;
      gpioStatus <= '0;
      busRData   <= '0;
    end else begin
      if (strobe.wr && coefHit)
        coef[coefOff[8:1]] <= strobe.wdata & (strobe.idx[1] ? 8'h80 : 8'hFF);
      if (strobe.wr && strobe.idx == ADDR_FILT_IDX)
        filtIdx <= {1'b0, strobe.wdata[FILT_IW-2:0]};
      else if (filtAcc && filtOpen)
        filtIdx <= filtIdx + 1'b1;
      if (strobe.wr && strobe.idx == ADDR_GAMMA_IDX)
        gammaIdx <= strobe.wdata[GAMMA_IW-1:0];
      else if (gammaAcc)
        gammaIdx <= gammaIdx + 1'b1;
      if (strobe.wr && strobe.idx == ADDR_PLL) pllDiv <= {1'b0, strobe.wdata[5:0]} + 7'd1;
      if (strobe.wr && strobe.idx == ADDR_NDP) ndpReg <= strobe.wdata & 8'h1B;
      gpioStatus <= ((strobe.wr && strobe.idx == ADDR_GPIO_IRQ) ?
                     (gpioStatus & strobe.wdata) : gpioStatus) | gpioEvent;
      if (strobe.rd) busRData <= {8'h00, rdByte};
    end
  end

  // Table storage, no reset
  always_ff @(posedge clk) begin
    if (strobe.wr && strobe.idx == ADDR_FILT_DATA && filtOpen)
      filtMem[filtIdx[FILT_IW-2:0]] <= strobe.wdata;
    if (strobe.wr && strobe.idx == ADDR_GAMMA_DATA)
      gammaMem[gammaIdx] <= strobe.wdata;
  end

  always_comb begin
    rdByte = 8'h00;
    if (coordHit) begin
      for (int k = 0; k < NUM_COORD; k++)
        if (coordOff[8:2] == 7'(k))
          rdByte = coordOff[1] ? 8'(coord[k][COORD_W-1:8]) : coord[k][7:0];
    end else if (coefHit) begin
      rdByte = coef[coefOff[8:1]];
    end else begin
      case (strobe.idx)
        ADDR_ID:         rdByte = ID_VALUE;
        ADDR_PLL:        rdByte = 8'h80 | 8'(pllDiv - 7'd1);
        ADDR_FILT_IDX:   rdByte = 8'(filtIdx);
        ADDR_FILT_DATA:  rdByte = filtOpen ? filtMem[filtIdx[FILT_IW-2:0]] : 8'h00;
        ADDR_GAMMA_IDX:  rdByte = 8'(gammaIdx);
        ADDR_GAMMA_DATA: rdByte = gammaMem[gammaIdx];
        ADDR_NDP:        rdByte = ndpReg | 8'h20;
        ADDR_GPIO_IRQ:   rdByte = gpioStatus;
        default:         rdByte = 8'h00;
      endcase
    end
  end

  assign gpioIrq = |gpioStatus;

  assert_filt_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    filtIdx <= FILT_IW'(FILT_DEPTH));
  assert_filt_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (filtAcc && !filtOpen) |=> filtIdx == FILT_IW'(FILT_DEPTH));
  assert_gamma_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    gammaAcc |=> gammaIdx == $past(gammaIdx) + 1'b1);
  assert_pll_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    pllDiv >= 7'd1 && pllDiv <= 7'd64);
  assert_gpio_and_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.idx == ADDR_GPIO_IRQ && gpioEvent == 8'h00)
      |=> gpioStatus == ($past(gpioStatus) & $past(strobe.wdata)));
  assert_rd_upper_R11: assert property (@(posedge clk) disable iff (!rstN)
    busRData[15:8] == 8'h00);
endmodule

// File: rtl/indexed_reg_port.sv
module indexed_reg_port
  import regport_pkg::*;
#(
  parameter int SWALLOW_COUNT = 2,
  parameter int NUM_COORD     = 4,
  parameter int COORD_W       = 10,
  parameter int FILT_DEPTH    = 32,
  parameter int GAMMA_DEPTH   = 256,
  parameter int NUM_COEF      = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrite,
  input  logic        busRead,
  input  logic        busCmd,
  input  logic [15:0] busWData,
  input  logic [7:0]  gpioEvent,
  output logic [15:0] busRData,
  output logic        gpioIrq
);
  portStrobe_t strobe;

  regport_ctrl #(.SWALLOW_COUNT(SWALLOW_COUNT), .STEP(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busCmd(busCmd), .busWData(busWData), .strobe(strobe));

  regport_regs #(.NUM_COORD(NUM_COORD), .COORD_W(COORD_W), .FILT_DEPTH(FILT_DEPTH),
                 .GAMMA_DEPTH(GAMMA_DEPTH), .NUM_COEF(NUM_COEF)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gpioEvent(gpioEvent),
    .busRData(busRData), .gpioIrq(gpioIrq));
endmodule

// File: tb/test_indexed_reg_port.sv
module test_indexed_reg_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0, busRead = 1'b0, busCmd = 1'b0;
  logic [15:0] busWData = '0;
  logic [7:0]  gpioEvent = '0;
  logic [15:0] busRData;
  logic        gpioIrq;
  int          checks = 0, fails = 0;
  logic [9:0]  coordModel [4];

  always #2.5 clk = ~clk;

  indexed_reg_port i_indexed_reg_port (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead), .busCmd(busCmd),
    .busWData(busWData), .gpioEvent(gpioEvent), .busRData(busRData), .gpioIrq(gpioIrq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic cmd, input logic [15:0] v);
    @(negedge clk);
    busWrite = 1'b1; busCmd = cmd; busWData = v;
    @(negedge clk);
    busWrite = 1'b0; busCmd = 1'b0;
  endtask

  task automatic busRd(output logic [15:0] v);
    @(negedge clk);
    busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    v = busRData;
  endtask

  function automatic logic [15:0] pllExpect(input logic [7:0] w);
    return {8'h00, 8'h80 | {2'b00, w[5:0]}};
  endfunction

  function automatic logic [15:0] coordExpect(input int k, input logic hi);
    return hi ? {14'h0, coordModel[k][9:8]} : {8'h00, coordModel[k][7:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int seedVal;
    seedVal = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("reset R11 rdata", busRData, 16'h0000);
    check("reset R8 irq", {15'h0, gpioIrq}, 16'h0000);

    // R3: two swallowed accesses
    busWr(1'b1, 16'h0002);
    busRd(r); check("R3 swallowed read", r, 16'h0000);
    busRd(r); check("R3 index untouched", r, 16'h0000);
    busRd(r); check("R2 advance to 0x02 / R9 id", r, 16'h0083);

    // R1 / R9: id ignores writes, command upper byte ignored
    busWr(1'b1, 16'hAB02); busWr(1'b0, 16'h0055);
    busWr(1'b1, 16'h0002); busRd(r); check("R1 R9 id readonly", r, 16'h0083);

    // R7
    busWr(1'b1, 16'h0004); busRd(r); check("R7 pll reset", r, 16'h0080);
    busWr(1'b1, 16'h0004); busWr(1'b0, 16'h00FF);
    busWr(1'b1, 16'h0004); busRd(r); check("R7 pll max", r, pllExpect(8'hFF));
    busWr(1'b1, 16'h0004); busWr(1'b0, 16'h006A);
    busWr(1'b1, 16'h0004); busRd(r); check("R7 pll mid", r, pllExpect(8'h6A));

    // R2 wrap 0xFE -> 0x00 -> 0x02
    busWr(1'b1, 16'h00FE);
    busRd(r); check("R11 unmapped 0xFE", r, 16'h0000);
    busRd(r); check("R2 wrap to 0x00", r, 16'h0000);
    busRd(r); check("R2 wrap then 0x02", r, 16'h0083);

    // R6 / R2: streaming fill of the coordinates
    busWr(1'b1, 16'h006C);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] lo = 8'h11 * 8'(k + 1);
      busWr(1'b0, {8'h00, lo});
      busWr(1'b0, 16'h00FF);
      coordModel[k] = {2'b11, lo};
    end
    busWr(1'b1, 16'h006C);
    for (int k = 0; k < 4; k++) begin
      busRd(r); check("R6 R2 coord lo", r, coordExpect(k, 1'b0));
      busRd(r); check("R6 R2 coord hi", r, coordExpect(k, 1'b1));
    end
    // R6 random field writes
    for (int n = 0; n < 40; n++) begin
      int k = int'($urandom_range(0, 3));
      logic hi = 1'($urandom_range(0, 1));
      logic [7:0] v = 8'($urandom);
      busWr(1'b1, {8'h00, 8'h6C + 8'(4 * k) + (hi ? 8'h02 : 8'h00)});
      busWr(1'b0, {8'h00, v});
      if (hi) coordModel[k][9:8] = v[1:0]; else coordModel[k][7:0] = v;
      k = int'($urandom_range(0, 3));
      busWr(1'b1, {8'h00, 8'h6C + 8'(4 * k)});
      busRd(r); check("R6 random lo", r, coordExpect(k, 1'b0));
      busRd(r); check("R6 random hi", r, coordExpect(k, 1'b1));
    end

    // R4 filter pointer cap
    busWr(1'b1, 16'h0058); busWr(1'b0, 16'h00FE);
    busWr(1'b0, 16'h00A1); busWr(1'b0, 16'h00B2); busWr(1'b0, 16'h00C3);
    busWr(1'b1, 16'h0058); busRd(r); check("R4 filter index capped", r, 16'h0020);
    busWr(1'b1, 16'h0058); busWr(1'b0, 16'h001E);
    busRd(r); check("R4 filter entry 30", r, 16'h00A1);
    busRd(r); check("R4 filter entry 31", r, 16'h00B2);
    busRd(r); check("R4 filter read at cap", r, 16'h0000);
    busWr(1'b1, 16'h0058); busWr(1'b0, 16'h0000);
    busRd(r); check("R4 entry 0 not overwritten", r === 16'h00C3 ? 16'h0001 : 16'h0000, 16'h0000);

    // R5 gamma wrap
    busWr(1'b1, 16'h00B6); busWr(1'b0, 16'h00FE);
    busWr(1'b0, 16'h0001); busWr(1'b0, 16'h0002); busWr(1'b0, 16'h0003);
    busWr(1'b1, 16'h00B6); busRd(r); check("R5 gamma index wrapped", r, 16'h0001);
    busWr(1'b1, 16'h00B6); busWr(1'b0, 16'h00FE);
    busRd(r); check("R5 gamma 0xFE", r, 16'h0001);
    busRd(r); check("R5 gamma 0xFF", r, 16'h0002);
    busRd(r); check("R5 gamma 0x00", r, 16'h0003);

    // R10 coefficient masks
    busWr(1'b1, 16'h00BC); busWr(1'b0, 16'h00FF); busWr(1'b0, 16'h00FF);
    busWr(1'b1, 16'h00DE); busWr(1'b0, 16'h007F);
    busWr(1'b1, 16'h00BC);
    busRd(r); check("R10 coef full byte", r, 16'h00FF);
    busRd(r); check("R10 coef bit7 only", r, 16'h0080);
    busWr(1'b1, 16'h00DE); busRd(r); check("R10 last coef masked", r, 16'h0000);

    // R9 non-display status
    busWr(1'b1, 16'h00E8); busRd(r); check("R9 ndp reset", r, 16'h0020);
    busWr(1'b1, 16'h00E8); busWr(1'b0, 16'h00FF);
    busWr(1'b1, 16'h00E8); busRd(r); check("R9 ndp mask", r, 16'h003B);

    // R8 write-to-clear status
    @(negedge clk); gpioEvent = 8'h0F;
    @(negedge clk); gpioEvent = 8'h00;
    check("R8 irq raised", {15'h0, gpioIrq}, 16'h0001);
    busWr(1'b1, 16'h00F6); busRd(r); check("R8 status set", r, 16'h000F);
    busWr(1'b1, 16'h00F6); busWr(1'b0, 16'h00FA);
    busWr(1'b1, 16'h00F6); busRd(r); check("R8 status AND", r, 16'h000A);
    busWr(1'b1, 16'h00F6); busWr(1'b0, 16'h0000);
    check("R8 irq cleared", {15'h0, gpioIrq}, 16'h0000);

    // R11 memory data port, read hold
    busWr(1'b1, 16'h0090); busWr(1'b0, 16'h1234);
    busRd(r); check("R11 mem port reads 0", r, 16'h0000);
    busWr(1'b1, 16'h0002); busRd(r);
    repeat (3) @(negedge clk);
    check("R11 rdata held", busRData, 16'h0083);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule